// File: doc/BRIEF.md
# Length-Framed Byte Stream Receiver

This block takes a byte stream arriving over a valid/ready handshake and cuts it into packets. A packet opens with a header byte. A length byte follows, and then exactly that many waveform sample bytes. The block forwards each sample byte on a held valid/ready output toward a DAC driver. The header and length bytes never reach the output.

A four-state sequencer tracks the position within the packet. Its 3-bit state code is driven continuously on a debug port for a logic analyser. The block trusts the framing and makes no attempt to recover from a corrupted stream. After the last sample byte of a packet is accepted, the sequencer spends one cooldown clock and then returns to idle.

Top module: `frame_rx`

## Requirements
- R1: While reset `rst_ni` is low, the block is in idle: `state_o` = 3'b010, `out_valid_o` = 0 and `in_ready_o` = 1.
- R2: In idle (`in_ready_o` = 1), an accepted byte equal to the header value (default 8'hA5) moves `state_o` to 3'b001 on the next clock. Any other accepted byte leaves `state_o` at 3'b010.
- R3: In the length state (3'b001), an accepted nonzero byte moves `state_o` to 3'b011 (transfer). An accepted zero byte moves it to 3'b101 (cooldown), and no sample is produced.
- R4: Each byte accepted in transfer appears on `out_data_o` with `out_valid_o` = 1 in the following cycle. Samples leave in arrival order.
- R5: While `out_valid_o` = 1 and `out_ready_i` = 0, `out_valid_o` stays 1 and `out_data_o` stays unchanged on the next clock.
- R6: In transfer, `in_ready_o` = (not `out_valid_o`) or `out_ready_i`. It is low while a sample is pending and not taken.
- R7: For a length byte N > 0, exactly N bytes are accepted in transfer. The clock that accepts the Nth byte moves `state_o` to 3'b101, and the clock after that moves it to 3'b010.
- R8: In cooldown, `in_ready_o` is 0, and cooldown lasts exactly one clock.
- R9: `state_o` only ever shows one of the four codes 3'b010, 3'b001, 3'b011, 3'b101.
- R10: Bytes accepted in idle, length or cooldown never raise `out_valid_o` or produce an output handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte ready |
| in_data_i | input | 8 | Input byte |
| out_valid_o | output | 1 | Sample valid, held until taken |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 8 | Sample byte |
| state_o | output | 3 | Current state code for debug |

## Verification
If the sequencer lands in the wrong state, `state_o` shows it on the very next clock. The same error also shows at the ports within a few cycles. A wrong count shows one of two ways. If the count runs short, a payload byte is taken as a header, and the output is missing samples. If the count runs long, the block stays in transfer and forwards the next header and length bytes as samples. A handshake fault drops or repeats a byte under backpressure, and that shows as a mismatch at the next output transfer. The reference model checks the state code, the input ready, the output valid and the output data on every clock, so the first wrong value is reported in the cycle it appears.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'b010,
    ST_LEN  = 3'b001,
    ST_XFER = 3'b011,
    ST_COOL = 3'b101
  } rx_state_e;
endpackage

// File: rtl/frame_rx_ctrl.sv
module frame_rx_ctrl
  import frame_rx_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter logic [DATA_W-1:0] HDR_VAL = 'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              pend_i,
  input  logic              out_ready_i,
  output logic              in_ready_o,
  output logic              load_o,
  output rx_state_e         state_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  rx_state_e         state_q, state_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              acc;

  always_comb begin
    unique case (state_q)
      ST_XFER: in_ready_o = ~pend_i | out_ready_i;
      ST_COOL: in_ready_o = 1'b0;
      default: in_ready_o = 1'b1;
    endcase
  end

  assign acc    = in_valid_i & in_ready_o;
  assign load_o = acc & (state_q == ST_XFER);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (acc && in_data_i == HDR_VAL) state_d = ST_LEN;
      ST_LEN: if (acc) begin
        cnt_d   = in_data_i;
        state_d = (in_data_i == '0) ? ST_COOL : ST_XFER;
      end
      ST_XFER: if (acc) begin
        cnt_d = cnt_q - ONE;
        if (cnt_q == ONE) state_d = ST_COOL;
      end
      ST_COOL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/frame_rx_out.sv
module frame_rx_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (load_i) begin
      out_valid_o <= 1'b1;
      out_data_o  <= data_i;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import frame_rx_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter logic [DATA_W-1:0] HDR_VAL = 'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [2:0]        state_o
);
  rx_state_e st;
  logic      load;

  frame_rx_ctrl #(.DATA_W(DATA_W), .HDR_VAL(HDR_VAL)) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .pend_i      (out_valid_o),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .load_o      (load),
    .state_o     (st)
  );

  frame_rx_out #(.DATA_W(DATA_W)) out_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .data_i      (in_data_i),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
  );

  assign state_o = st;
endmodule

// File: rtl/frame_rx_chk.sv
module frame_rx_chk #(
  parameter int          DATA_W  = 8,
  parameter logic [DATA_W-1:0] HDR_VAL = 'hA5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [DATA_W-1:0] in_data_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic [2:0]        state_o
);
  localparam logic [2:0] S_IDLE = 3'b010;
  localparam logic [2:0] S_LEN  = 3'b001;
  localparam logic [2:0] S_XFER = 3'b011;
  localparam logic [2:0] S_COOL = 3'b101;

  logic acc;
  assign acc = in_valid_i & in_ready_o;

  // R2
  bad_hdr_stays_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_IDLE && acc && in_data_i != HDR_VAL) |=> state_o == S_IDLE);

  // R2
  hdr_to_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_IDLE && acc && in_data_i == HDR_VAL) |=> state_o == S_LEN);

  // R3
  zero_len_cool_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_LEN && acc && in_data_i == '0) |=> state_o == S_COOL);

  // R4
  xfer_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_XFER && acc) |=> (out_valid_o && out_data_o == $past(in_data_i)));

  // R5
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  // R6
  backpressure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_XFER && out_valid_o && !out_ready_i) |-> !in_ready_o);

  // R8
  cool_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_COOL) |-> !in_ready_o);

  // R7
  cool_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_COOL) |=> state_o == S_IDLE);

  // R9
  legal_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_IDLE || state_o == S_LEN || state_o == S_XFER || state_o == S_COOL));

  // R10
  no_spurious_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != S_XFER) |=> !$rose(out_valid_o));
endmodule

bind frame_rx frame_rx_chk #(.DATA_W(DATA_W), .HDR_VAL(HDR_VAL)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_data_i   (in_data_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .state_o     (state_o)
);

// File: tb/frame_rx_tb_top.sv
`timescale 1ns/1ps
module frame_rx_tb_top;
  localparam logic [2:0] S_IDLE = 3'b010;
  localparam logic [2:0] S_LEN  = 3'b001;
  localparam logic [2:0] S_XFER = 3'b011;
  localparam logic [2:0] S_COOL = 3'b101;
  localparam logic [7:0] HDR    = 8'hA5;
  localparam int         MAX_CYC = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, out_valid, out_ready;
  logic [7:0] in_data, out_data;
  logic [2:0] state;

  always #10 clk = ~clk;

  frame_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .state_o(state)
  );

  int         n_tests = 0, n_fail = 0, cycles = 0;
  int         n_out = 0, exp_total = 0;
  int         pv = 100, pr = 100;
  bit         timed_out = 0;
  logic [7:0] stream[$];

  // reference model state
  logic [2:0] m_state = S_IDLE;
  int         m_cnt = 0;
  logic       m_ov = 1'b0;
  logic [7:0] m_od = 8'h00;
  logic       m_held = 1'b0;

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic push_pkt(int len);
    stream.push_back(HDR);
    stream.push_back(8'(len));
    for (int i = 0; i < len; i++) stream.push_back(8'($urandom));
    exp_total += len;
  endtask

  task automatic run_phase();
    logic       held_in = 1'b0;
    logic       exp_rdy, acc, take;
    logic [7:0] b;
    while (!timed_out && (stream.size() > 0 || m_ov || m_state != S_IDLE)) begin
      @(negedge clk);
      cycles++;
      if (cycles > MAX_CYC) begin
        timed_out = 1;
        chk("watchdog", 1, 0);
        break;
      end
      if (!held_in) begin
        if (stream.size() > 0 && ($urandom % 100) < pv) begin
          in_valid = 1'b1;
          in_data  = stream[0];
        end else begin
          in_valid = 1'b0;
          in_data  = 8'($urandom);
        end
      end
      out_ready = (($urandom % 100) < pr);
      #1;
      exp_rdy = (m_state == S_COOL) ? 1'b0 :
                (m_state == S_XFER) ? (!m_ov || out_ready) : 1'b1;
      chk(m_state == S_COOL ? "R7 state cooldown" :
          m_state == S_LEN  ? "R2 state length" :
          m_state == S_XFER ? "R3 state transfer" : "R9 state idle",
          state, m_state);
      chk(m_state == S_COOL ? "R8 ready" : m_state == S_XFER ? "R6 ready" : "R2 ready",
          in_ready, exp_rdy);
      chk("R4 out_valid", out_valid, m_ov);
      if (m_ov) chk(m_held ? "R5 held data" : "R4 data", out_data, m_od);
      acc  = in_valid && exp_rdy;
      take = m_ov && out_ready;
      if (out_valid && out_ready) n_out++;
      b = in_data;
      m_held = m_ov && !out_ready;
      if (acc) begin
        void'(stream.pop_front());
        held_in = 1'b0;
      end else begin
        held_in = in_valid;
      end
      if (acc && m_state == S_XFER) begin
        m_ov = 1'b1;
        m_od = b;
      end else if (take) begin
        m_ov = 1'b0;
      end
      case (m_state)
        S_IDLE: if (acc && b == HDR) m_state = S_LEN;
        S_LEN: if (acc) begin
          m_cnt   = b;
          m_state = (b == 0) ? S_COOL : S_XFER;
        end
        S_XFER: if (acc) begin
          m_cnt--;
          if (m_cnt == 0) m_state = S_COOL;
        end
        default: m_state = S_IDLE;
      endcase
    end
  endtask

  initial begin
    int base;
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset state", state, S_IDLE);
    chk("R1 reset valid", out_valid, 0);
    chk("R1 reset ready", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R7 plain 8-byte packet
    pv = 100; pr = 100;
    push_pkt(8);
    run_phase();
    chk("R7 eight samples out", n_out, 8);

    // R10 non-header bytes and zero-length packet give no output
    base = n_out;
    stream.push_back(8'h33); stream.push_back(8'h00); stream.push_back(8'hFF);
    push_pkt(0);
    run_phase();
    chk("R10 no output from framing bytes", n_out - base, 0);

    // R3 single-byte packet
    push_pkt(1);
    run_phase();
    chk("R3 one sample", n_out - base, 1);

    // R5 R6 heavy backpressure
    pr = 20;
    push_pkt(16);
    run_phase();

    // mixed random traffic with stray non-header bytes
    pv = 60; pr = 50;
    for (int k = 0; k < 12; k++) begin
      if (k % 4 == 3) stream.push_back(8'h5A);
      push_pkt(int'($urandom % 41));
    end
    run_phase();

    // maximum length
    pv = 100; pr = 100;
    push_pkt(255);
    run_phase();

    chk("R7 total samples", n_out, exp_total);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule